// File: doc/BRIEF.md
# Sequential Line Prefetch Buffer

This block sits beside a cache on its refill path. When the cache misses, it presents the missing line address to this block. If the address matches the head of one of the stream buffers, that line is handed back at once and the buffer pops it. The buffer then asks the next memory level for one further line so that it stays full. If no buffer head matches, the block reports a miss, and the cache fetches the line itself. The least-recently-used buffer is then cleared and restarted at the line after the one that missed. Prefetched lines live only in the buffers; nothing is written into the cache by this block.

Several buffers work side by side, so that interleaved sequential reference streams are each followed by their own buffer. Each entry carries a tag, a valid state and a pending state. Requests to the next level are pipelined: many can be in flight at once, and their responses come back in request order. When a lookup hits a head whose data is still in flight, it is held off until the line arrives. Responses that belong to a buffer which has since been restarted are discarded.

Top module: `seqline_prefetch`

## Requirements
- R1: While reset is asserted and in the cycle after it, no lookup response and no memory request is driven. After reset every buffer is idle, so the first lookup of any line misses.
- R2: A lookup that matches no buffer head gets a response with rsp_hit=0 in the cycle after it is accepted. The least-recently-used buffer then requests lines miss+1, miss+2, and so on, in that order, wrapping modulo 2^ADDR_W. It stops after DEPTH requests are outstanding without a pop.
- R3: The number of memory requests accepted but not yet answered never exceeds WAYS*DEPTH.
- R4: A lookup that matches a head whose data has arrived gets, in the cycle after acceptance, rsp_hit=1, rsp_line equal to the looked-up line, and rsp_data equal to the memory data of that line. The head is popped, and that buffer later requests the line after its current last line.
- R5: A lookup that matches a head whose data is still in flight sees miss_ready=0 until the data arrives. It is then accepted and answered as in R4.
- R6: Only head entries are compared. A line held deeper in a buffer misses, and it restarts a buffer.
- R7: Interleaved sequential streams, one per buffer, each keep hitting in their own buffer.
- R8: On a miss, the buffer restarted is the one whose last hit or restart is oldest. After reset, the ages run so that buffer WAYS-1 is the oldest and buffer 0 the newest. When several heads match, the lowest-numbered buffer supplies the line.
- R9: Memory responses fill entries in request order. Responses for requests made before a buffer was restarted are discarded and never supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a missing line address |
| miss_line | input | ADDR_W | Missing line address |
| miss_ready | output | 1 | Lookup accepted this cycle when high with miss_valid |
| rsp_valid | output | 1 | Lookup result valid (registered) |
| rsp_hit | output | 1 | 1: line supplied from a buffer; 0: not held |
| rsp_line | output | ADDR_W | Line address of the result |
| rsp_data | output | DATA_W | Line data when rsp_hit=1 |
| mem_req_valid | output | 1 | Fetch request to the next level |
| mem_req_line | output | ADDR_W | Line address requested |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_rsp_valid | input | 1 | Response data valid, in request order |
| mem_rsp_data | input | DATA_W | Response data |

## Verification
The case that needs the most care is a single buffer doing two things in one cycle. A memory response lands in an entry of that buffer in the same cycle as a lookup pops its head, and often the buffer also wins a new request slot then. A related case is a stalled lookup that is released by the very fill of the head it waits on. These cases are provoked by random response latencies from zero cycles up, random request-ready gaps, and a directed long-latency lookup on the line just after a miss. The results are judged by comparing every supplied line against a pattern derived from its address, and by checking the order of requested lines. A fill that is lost, doubled or misplaced shows up as wrong data or a wrong hit or miss outcome.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
  typedef struct packed {
    logic hit;
    logic ready;
  } head_stat_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/spf_way.sv
`timescale 1ns/1ps
module spf_way
  import spf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int DROP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_line,
  input  logic              pop,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_line,
  input  logic              grant,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output head_stat_t        stat,
  output logic [DATA_W-1:0] head_data,
  output logic              want_req,
  output logic [ADDR_W-1:0] req_line
);
  localparam int PTR_W = idx_w(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic              active;
  logic [ADDR_W-1:0] nxt;
  logic [PTR_W-1:0]  hd, tl, fp;
  logic [OCC_W-1:0]  occ, npend;
  logic [DROP_W-1:0] drop;
  logic [DEPTH-1:0]  pnd;
  logic [ADDR_W-1:0] tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic              live_fill;
  logic [DROP_W-1:0] drop_d;
  logic [OCC_W-1:0]  occ_d, npend_d;
  logic [ADDR_W-1:0] head_tag;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    live_fill = fill_valid && (drop == '0);
    drop_d    = drop - DROP_W'(fill_valid && (drop != '0));
    npend_d   = npend + OCC_W'(grant) - OCC_W'(live_fill);
    occ_d     = occ + OCC_W'(grant) - OCC_W'(pop);
    head_tag  = (occ != '0) ? tag_q[hd] : nxt;
  end

  assign stat.hit   = active && (head_tag == lk_line);
  assign stat.ready = (occ != '0) && !pnd[hd];
  assign head_data  = data_q[hd];
  assign want_req   = active && (occ < OCC_W'(DEPTH)) && !flush;
  assign req_line   = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      nxt    <= '0;
      hd     <= '0;
      tl     <= '0;
      fp     <= '0;
      occ    <= '0;
      npend  <= '0;
      drop   <= '0;
      pnd    <= '0;
    end else if (flush) begin
      active <= 1'b1;
      nxt    <= flush_line + 1'b1;
      hd     <= '0;
      tl     <= '0;
      fp     <= '0;
      occ    <= '0;
      npend  <= '0;
      drop   <= drop_d + DROP_W'(npend_d);
    end else begin
      occ   <= occ_d;
      npend <= npend_d;
      drop  <= drop_d;
      if (pop) hd <= bump(hd);
      if (grant) begin
        tl      <= bump(tl);
        nxt     <= nxt + 1'b1;
        pnd[tl] <= 1'b1;
      end
      if (live_fill) begin
        fp      <= bump(fp);
        pnd[fp] <= 1'b0;
      end
    end
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (grant) tag_q[tl] <= nxt;
    if (live_fill) data_q[fp] <= fill_data;
  end
endmodule

// File: rtl/spf_lru.sv
`timescale 1ns/1ps
module spf_lru
  import spf_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   touch,
  input  logic [idx_w(WAYS)-1:0] touch_way,
  output logic [idx_w(WAYS)-1:0] victim
);
  localparam int WAY_W = idx_w(WAYS);

  logic [WAY_W-1:0] age [WAYS];

  always_comb begin
    victim = '0;
    for (int i = 0; i < WAYS; i++)
      if (age[i] == WAY_W'(WAYS - 1)) victim = WAY_W'(i);
  end

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_age
      always_ff @(posedge clk) begin
        if (rst) age[g] <= WAY_W'(g);
        else if (touch) begin
          if (touch_way == WAY_W'(g)) age[g] <= '0;
          else if (age[g] < age[touch_way]) age[g] <= age[g] + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/spf_req_arb.sv
`timescale 1ns/1ps
module spf_req_arb
  import spf_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  parameter int OUTS   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WAYS-1:0]              want,
  input  logic [WAYS-1:0][ADDR_W-1:0]  lines,
  input  logic                         mem_req_ready,
  input  logic                         mem_rsp_valid,
  output logic                         mem_req_valid,
  output logic [ADDR_W-1:0]            mem_req_line,
  output logic [WAYS-1:0]              grant,
  output logic                         fill_valid,
  output logic [idx_w(WAYS)-1:0]       fill_way,
  output logic                         q_full
);
  localparam int WAY_W = idx_w(WAYS);
  localparam int QP_W  = idx_w(OUTS);
  localparam int QC_W  = $clog2(OUTS + 1);

  logic [WAY_W-1:0] pick;
  logic             any;
  logic [WAY_W-1:0] q_mem [OUTS];
  logic [QP_W-1:0]  wp, rp;
  logic [QC_W-1:0]  cnt;
  logic             push, popq;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (want[i]) begin
        pick = WAY_W'(i);
        any  = 1'b1;
      end
  end

  assign q_full        = (cnt == QC_W'(OUTS));
  assign mem_req_valid = any && !q_full;
  assign mem_req_line  = lines[pick];
  assign push          = mem_req_valid && mem_req_ready;
  assign popq          = mem_rsp_valid && (cnt != '0);
  assign fill_valid    = popq;
  assign fill_way      = q_mem[rp];

  always_comb begin
    grant = '0;
    if (push) grant[pick] = 1'b1;
  end

  function automatic logic [QP_W-1:0] qbump(input logic [QP_W-1:0] p);
    return (p == QP_W'(OUTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= qbump(wp);
      if (popq) rp <= qbump(rp);
      cnt <= cnt + QC_W'(push) - QC_W'(popq);
    end
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[wp] <= pick;
  end
endmodule

// File: rtl/seqline_prefetch.sv
`timescale 1ns/1ps
module seqline_prefetch
  import spf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_line,
  output logic              miss_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_line,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_line,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int OUTS   = WAYS * DEPTH;
  localparam int DROP_W = $clog2(OUTS + 1);
  localparam int WAY_W  = idx_w(WAYS);

  head_stat_t                  st    [WAYS];
  logic [DATA_W-1:0]           hdata [WAYS];
  logic [WAYS-1:0]             want, want_m, grant, pop, flush, fillv;
  logic [WAYS-1:0][ADDR_W-1:0] rline;
  logic                        any_hit, sel_ready, accept;
  logic [WAY_W-1:0]            sel, victim, fill_way;
  logic                        fill_any, tagq_full;

  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (st[i].hit) begin
        any_hit = 1'b1;
        sel     = WAY_W'(i);
      end
  end

  assign sel_ready  = st[sel].ready;
  assign miss_ready = !any_hit || sel_ready;
  assign accept     = miss_valid && miss_ready;

  always_comb begin
    pop   = '0;
    flush = '0;
    if (accept && any_hit)  pop[sel]     = 1'b1;
    if (accept && !any_hit) flush[victim] = 1'b1;
  end

  assign want_m = want & ~flush;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_way
      assign fillv[g] = fill_any && (fill_way == WAY_W'(g));
      spf_way #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .DROP_W(DROP_W)
      ) u_way (
        .clk       (clk),
        .rst       (rst),
        .lk_line   (miss_line),
        .pop       (pop[g]),
        .flush     (flush[g]),
        .flush_line(miss_line),
        .grant     (grant[g]),
        .fill_valid(fillv[g]),
        .fill_data (mem_rsp_data),
        .stat      (st[g]),
        .head_data (hdata[g]),
        .want_req  (want[g]),
        .req_line  (rline[g])
      );
    end
  endgenerate

  spf_lru #(.WAYS(WAYS)) u_lru (
    .clk      (clk),
    .rst      (rst),
    .touch    (accept),
    .touch_way(any_hit ? sel : victim),
    .victim   (victim)
  );

  spf_req_arb #(.WAYS(WAYS), .ADDR_W(ADDR_W), .OUTS(OUTS)) u_arb (
    .clk          (clk),
    .rst          (rst),
    .want         (want_m),
    .lines        (rline),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_line (mem_req_line),
    .grant        (grant),
    .fill_valid   (fill_any),
    .fill_way     (fill_way),
    .q_full       (tagq_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_line  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit  <= any_hit;
        rsp_line <= miss_line;
        rsp_data <= any_hit ? hdata[sel] : '0;
      end
    end
  end
endmodule

// File: rtl/spf_checker.sv
`timescale 1ns/1ps
module spf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_line,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_line,
  input logic              mem_req_valid,
  input logic              tagq_full
);
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !mem_req_valid));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    tagq_full |-> !mem_req_valid);

  p_rsp_follows_accept_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(miss_valid && miss_ready));

  p_rsp_line_echo_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_line == $past(miss_line)));

  p_stall_no_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_ready) |=> !rsp_valid);
endmodule

bind seqline_prefetch spf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .miss_line    (miss_line),
  .rsp_valid    (rsp_valid),
  .rsp_line     (rsp_line),
  .mem_req_valid(mem_req_valid),
  .tagq_full    (tagq_full)
);

// File: tb/seqline_prefetch_test.sv
`timescale 1ns/1ps
module seqline_prefetch_test;
  localparam int AW = 16, DW = 32, DEPTH = 4, WAYS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          miss_valid = 1'b0;
  logic [AW-1:0] miss_line = '0;
  logic          miss_ready, rsp_valid, rsp_hit;
  logic [AW-1:0] rsp_line;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic [AW-1:0] mem_req_line;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  seqline_prefetch #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .WAYS(WAYS)) uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expdata(input logic [AW-1:0] l);
    return {l ^ 16'hA5C3, ~l};
  endfunction

  // memory model
  int q_line[$], q_due[$], req_log[$];
  int cyc = 0, outs = 0, lat_min = 0, lat_max = 0, rdy_pct = 100;
  bit rsp_en = 0, ovf = 0;

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_req_ready = ($urandom % 100) < rdy_pct;
      if (rsp_en && q_line.size() > 0 && cyc >= q_due[0]) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = expdata(q_line[0][AW-1:0]);
      end else begin
        mem_rsp_valid = 1'b0;
      end
      #8;
      if (rst) begin
        q_line.delete(); q_due.delete(); outs = 0;
      end else begin
        if (mem_rsp_valid) begin
          void'(q_line.pop_front()); void'(q_due.pop_front()); outs--;
        end
        if (mem_req_valid && mem_req_ready) begin
          q_line.push_back(int'(mem_req_line));
          q_due.push_back(cyc + 1 + $urandom_range(lat_min, lat_max));
          req_log.push_back(int'(mem_req_line));
          outs++;
          if (outs > WAYS * DEPTH) ovf = 1;
        end
      end
    end
  end

  // reference model of the buffer heads
  bit act[WAYS];
  int hl[WAYS], stamp[WAYS], tick;

  task automatic model_reset();
    for (int i = 0; i < WAYS; i++) begin
      act[i] = 0; hl[i] = 0; stamp[i] = WAYS - 1 - i;
    end
    tick = WAYS;
  endtask

  task automatic model_access(input int line, output bit hit);
    int w = -1, v = 0;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && act[i] && hl[i] == line) w = i;
    if (w >= 0) begin
      hit = 1; hl[w] = (line + 1) & 16'hFFFF; stamp[w] = tick++;
    end else begin
      hit = 0;
      for (int i = 1; i < WAYS; i++) if (stamp[i] < stamp[v]) v = i;
      act[v] = 1; hl[v] = (line + 1) & 16'hFFFF; stamp[v] = tick++;
    end
  endtask

  int last_stall;

  task automatic lookup(input int line, input string req);
    bit eh;
    int stall = 0;
    model_access(line, eh);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_line  = line[AW-1:0];
    #8;
    while (!miss_ready && stall < 2000) begin
      stall++;
      @(negedge clk);
      #8;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    last_stall = stall;
    check(stall < 2000, {req, " lookup accepted"}, stall, 0);
    check(rsp_valid == 1'b1, {req, " rsp_valid"}, rsp_valid, 1);
    check(rsp_line == line[AW-1:0], {req, " rsp_line"}, rsp_line, line);
    check(rsp_hit == eh, {req, " rsp_hit"}, rsp_hit, eh);
    if (eh) check(rsp_data == expdata(line[AW-1:0]), {req, " rsp_data"}, rsp_data, expdata(line[AW-1:0]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s[3];
    bit dummy;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #8;
    // R1: reset state
    check(rsp_valid == 0, "R1 rsp_valid idle", rsp_valid, 0);
    check(mem_req_valid == 0, "R1 no request", mem_req_valid, 0);
    check(miss_ready == 1, "R1 miss_ready", miss_ready, 1);

    // R2: miss starts a stream, exactly DEPTH requests
    rdy_pct = 100; rsp_en = 0; lat_min = 2; lat_max = 2;
    lookup(100, "R1 R2 first miss");
    repeat (10) @(negedge clk);
    check(req_log.size() == DEPTH, "R2 request count", req_log.size(), DEPTH);
    for (int i = 0; i < DEPTH && i < req_log.size(); i++)
      check(req_log[i] == 101 + i, "R2 request order", req_log[i], 101 + i);
    rsp_en = 1;
    repeat (10) @(negedge clk);
    // R4: head hit, then refill of the next line
    lookup(101, "R4 head hit");
    repeat (6) @(negedge clk);
    check(req_log[req_log.size()-1] == 101 + DEPTH, "R4 refill line", req_log[req_log.size()-1], 101 + DEPTH);
    // R6: deeper entry misses
    lookup(103, "R6 non-head");
    lookup(102, "R6 old stream head");

    // R2 wrap
    lookup(16'hFFFF, "R2 wrap miss");
    repeat (8) @(negedge clk);
    lookup(0, "R2 wrap hit");

    // R8: LRU victim choice
    do_reset();
    lat_min = 1; lat_max = 1;
    lookup(10, "R8"); lookup(20, "R8"); lookup(30, "R8"); lookup(40, "R8");
    repeat (10) @(negedge clk);
    lookup(11, "R8 hit");
    lookup(50, "R8 miss");
    lookup(21, "R8 evicted stream");
    lookup(31, "R8 kept stream");
    lookup(41, "R8 kept stream");

    // R9: restart a buffer with requests in flight
    lat_min = 40; lat_max = 40;
    lookup(300, "R9"); lookup(400, "R9"); lookup(500, "R9"); lookup(600, "R9");
    lookup(700, "R9 restart busy buffer");
    lat_min = 1; lat_max = 1;
    lookup(701, "R9 fresh data");
    lookup(702, "R9 fresh data");
    lookup(703, "R9 fresh data");

    // R5: stall on pending head
    lat_min = 25; lat_max = 25;
    lookup(800, "R5 miss");
    lookup(801, "R5 pending hit");
    check(last_stall > 0, "R5 stalled", last_stall, 1);

    // R7: interleaved streams with random timing
    lat_min = 0; lat_max = 6; rdy_pct = 80;
    s[0] = 1000; s[1] = 5000; s[2] = 9000;
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 2);
      if (($urandom % 100) < 12) s[k] = $urandom_range(0, 16'hFFF0);
      lookup(s[k], "R7 R9 interleaved");
      s[k] = (s[k] + 1) & 16'hFFFF;
      if (($urandom % 4) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check(!ovf, "R3 outstanding bound", ovf, 0);
    check(outs == 0, "R3 all answered", outs, 0);
    dummy = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule